// File: doc/BRIEF.md
# LDPC Frame Segmenter with Shortening

The segmenter cuts a payload of arbitrary bit length into information blocks for an LDPC encoder. Codeword length n and code rate are chosen when a payload starts, and k is n times the rate. Every block but the last carries k payload bits. A remainder of k1 = L mod k bits forms a shorter last block. Before it reaches the encoder, that block is topped up with zeros to k bits.

The encoder's parity bits come back on a separate input. They are forwarded to the transmit stream after the information bits of the same frame. The zero fill bits are dropped on the way to air, so a short frame occupies k1 + (n-k) bits. In parallel, a small divider reports the frame count and the size of the last frame. All three streams use valid/ready handshakes. A last-frame flag travels with every beat of the final frame, so downstream logic can treat that frame differently, for example by running fewer decoding iterations on it.

The controller is a four-state machine:
- **IDLE** waits for a start.
- **INFO** forwards payload bits to the encoder and the transmitter together.
- **FILL** feeds zeros to the encoder only.
- **PARITY** forwards encoder parity to the transmitter.

It has six transitions:
- IDLE→INFO on a start with a nonzero length.
- INFO→FILL when a short frame's payload is exhausted.
- INFO→PARITY when a full frame's k bits are sent.
- FILL→PARITY after the k-th encoder bit.
- PARITY→INFO after the last parity bit of a frame that is not the last.
- PARITY→IDLE after the last parity bit of the last frame.

Top module: `ldpc_frame_segmenter`

## Requirements
- R1: `n_sel` picks the codeword length n = 24·UNIT·m, with m=1 for code 0, m=2 for code 1 and m=3 for codes 2 and 3. `rate_sel` codes 0,1,2,3 pick rates 1/2, 2/3, 3/4, 5/6. With UNIT=27 this gives n of 648, 1296 or 1944. Both selects are sampled with `start`.
- R2: For L>0, `rpt_frames` = ceil(L/k) and `rpt_last` = L − (rpt_frames−1)·k, which equals k when L is a multiple of k. For L=0 both read 0 and no beat appears on any stream.
- R3: Let E0 be the clock edge that samples an accepted `start`. For L>0, `rpt_valid` is high after edge E0 + floor((L−1)/k) + 1. For L=0 it is high right after E0. It then stays high until the next accepted start.
- R4: Every frame gives exactly k encoder beats. The frame's payload bits come first, in arrival order. Zeros follow, up to k.
- R5: `enc_last` is high exactly on the k-th encoder beat of each frame. `enc_final` is high on every encoder beat of the last frame and on no other beat.
- R6: Each frame on the transmit stream carries its payload bits first, then exactly n−k bits taken from `par_data` in arrival order. Fill zeros never appear on it.
- R7: `tx_eof` marks the last parity beat of each frame. `tx_final` is high on every beat of the last frame. Total transmit beats equal L + rpt_frames·(n−k).
- R8: `in_ready` is high only when both `enc_ready` and `tx_ready` are high. `par_ready` is high only in the parity phase, and then equals `tx_ready`. The two are never high together.
- R9: A `start` while a payload is in progress has no effect on the streams or on the report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a payload (accepted only when idle) |
| pay_len | input | LEN_W | Payload length L in bits |
| n_sel | input | 2 | Codeword length select |
| rate_sel | input | 2 | Code rate select |
| in_data | input | 1 | Payload bit |
| in_valid | input | 1 | Payload bit valid |
| in_ready | output | 1 | Payload bit accepted |
| enc_data | output | 1 | Bit to encoder (payload or fill zero) |
| enc_valid | output | 1 | Encoder beat valid |
| enc_ready | input | 1 | Encoder accepts beat |
| enc_last | output | 1 | k-th bit of a frame |
| enc_final | output | 1 | Beat belongs to the last frame |
| par_data | input | 1 | Parity bit from encoder |
| par_valid | input | 1 | Parity bit valid |
| par_ready | output | 1 | Parity bit accepted |
| tx_data | output | 1 | Bit to transmitter |
| tx_valid | output | 1 | Transmit beat valid |
| tx_ready | input | 1 | Transmitter accepts beat |
| tx_eof | output | 1 | Last bit of a frame on air |
| tx_final | output | 1 | Beat belongs to the last frame |
| rpt_valid | output | 1 | Report fields valid |
| rpt_frames | output | LEN_W | Number of frames |
| rpt_last | output | CW | Information bits in the last frame |

## Verification
The stream outputs are combinational from the state and the handshake inputs. The bench therefore drives inputs on the falling edge and evaluates handshakes 1 ns later. Any beat seen then completes on the following rising edge, and each beat is compared with the bit the arithmetic model expects at that frame position. The report needs a known number of edges after the start edge: floor((L−1)/k)+1 of them, or none for an empty payload. The bench counts rising edges after E0, sampling 1 ns after each, and compares that count exactly. The sweep covers all sixteen select codes at UNIT=1, with lengths 0, 1, k−1, k, k+1, 2k, 2k+5, 3k−1 and two random values. Random backpressure is applied on every stream, and a stray start is injected during multi-frame payloads.

// File: rtl/seg_pkg.sv
package seg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_INFO   = 2'd1,
        ST_FILL   = 2'd2,
        ST_PARITY = 2'd3
    } seg_state_e;

    // information units per base block (out of 24) for each rate code
    function automatic logic [4:0] info_units(input logic [1:0] rate_code);
        unique case (rate_code)
            2'd0:    return 5'd12;
            2'd1:    return 5'd16;
            2'd2:    return 5'd18;
            default: return 5'd20;
        endcase
    endfunction

    // codeword length multiple for each length code
    function automatic logic [1:0] len_mult(input logic [1:0] len_code);
        unique case (len_code)
            2'd0:    return 2'd1;
            2'd1:    return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/seg_cfg.sv
module seg_cfg
    import seg_pkg::*;
#(
    parameter int UNIT = 27,
    localparam int CW  = $clog2(72 * UNIT + 1)
) (
    input  logic [1:0]    n_sel,
    input  logic [1:0]    rate_sel,
    output logic [CW-1:0] k_bits,
    output logic [CW-1:0] p_bits
);
    logic [CW-1:0] n_bits;

    always_comb begin
        n_bits = CW'(UNIT * 24 * int'(len_mult(n_sel)));
        k_bits = CW'(UNIT * int'(len_mult(n_sel)) * int'(info_units(rate_sel)));
        p_bits = n_bits - k_bits;
    end
endmodule

// File: rtl/seg_div.sv
module seg_div #(
    parameter int LEN_W = 16,
    parameter int CW    = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic [CW-1:0]    k_bits,
    output logic             rpt_valid,
    output logic [LEN_W-1:0] rpt_frames,
    output logic [CW-1:0]    rpt_last
);
    logic [LEN_W-1:0] rem;
    logic [LEN_W-1:0] quot;
    logic [CW-1:0]    kk;
    logic             busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem        <= '0;
            quot       <= '0;
            kk         <= '0;
            busy       <= 1'b0;
            rpt_valid  <= 1'b0;
            rpt_frames <= '0;
            rpt_last   <= '0;
        end else if (load) begin
            rem        <= len;
            quot       <= '0;
            kk         <= k_bits;
            busy       <= (len != '0);
            rpt_valid  <= (len == '0);
            rpt_frames <= '0;
            rpt_last   <= '0;
        end else if (busy) begin
            if (rem > LEN_W'(kk)) begin
                rem  <= rem - LEN_W'(kk);
                quot <= quot + 1'b1;
            end else begin
                busy       <= 1'b0;
                rpt_valid  <= 1'b1;
                rpt_frames <= quot + 1'b1;
                rpt_last   <= rem[CW-1:0];
            end
        end
    end

    AST_LAST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && rpt_frames != '0) |-> (rpt_last != '0 && rpt_last <= kk)); // R2

    AST_REPORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && !load) |=> rpt_valid); // R3
endmodule

// File: rtl/ldpc_frame_segmenter.sv
module ldpc_frame_segmenter
    import seg_pkg::*;
#(
    parameter int UNIT  = 27,
    parameter int LEN_W = 16,
    localparam int CW   = $clog2(72 * UNIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] pay_len,
    input  logic [1:0]       n_sel,
    input  logic [1:0]       rate_sel,
    input  logic             in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             enc_data,
    output logic             enc_valid,
    input  logic             enc_ready,
    output logic             enc_last,
    output logic             enc_final,
    input  logic             par_data,
    input  logic             par_valid,
    output logic             par_ready,
    output logic             tx_data,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic             tx_eof,
    output logic             tx_final,
    output logic             rpt_valid,
    output logic [LEN_W-1:0] rpt_frames,
    output logic [CW-1:0]    rpt_last
);
    seg_state_e       state;
    logic [CW-1:0]    k_c, p_c;
    logic [CW-1:0]    k_r, p_r;
    logic [LEN_W-1:0] left;
    logic [CW-1:0]    fr_info;
    logic [CW-1:0]    cnt;
    logic             last_fr;
    logic             accept;
    logic             in_fire, par_fire;

    seg_cfg #(.UNIT(UNIT)) u_cfg (
        .n_sel   (n_sel),
        .rate_sel(rate_sel),
        .k_bits  (k_c),
        .p_bits  (p_c)
    );

    seg_div #(.LEN_W(LEN_W), .CW(CW)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .len       (pay_len),
        .k_bits    (k_c),
        .rpt_valid (rpt_valid),
        .rpt_frames(rpt_frames),
        .rpt_last  (rpt_last)
    );

    assign accept   = start && (state == ST_IDLE);
    assign in_fire  = in_valid && in_ready;
    assign par_fire = par_valid && par_ready;

    // state register and frame bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            k_r     <= '0;
            p_r     <= '0;
            left    <= '0;
            fr_info <= '0;
            cnt     <= '0;
            last_fr <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        k_r     <= k_c;
                        p_r     <= p_c;
                        left    <= pay_len;
                        cnt     <= '0;
                        fr_info <= (pay_len > LEN_W'(k_c)) ? k_c : pay_len[CW-1:0];
                        last_fr <= (pay_len <= LEN_W'(k_c));
                        if (pay_len != '0) state <= ST_INFO;
                    end
                end
                ST_INFO: begin
                    if (in_fire) begin
                        left <= left - 1'b1;
                        if (cnt == fr_info - CW'(1)) begin
                            if (fr_info < k_r) begin
                                cnt   <= cnt + 1'b1;
                                state <= ST_FILL;
                            end else begin
                                cnt   <= '0;
                                state <= ST_PARITY;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_FILL: begin
                    if (enc_ready) begin
                        if (cnt == k_r - CW'(1)) begin
                            cnt   <= '0;
                            state <= ST_PARITY;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_PARITY: begin
                    if (par_fire) begin
                        if (cnt == p_r - CW'(1)) begin
                            cnt <= '0;
                            if (last_fr) begin
                                state <= ST_IDLE;
                            end else begin
                                state   <= ST_INFO;
                                fr_info <= (left > LEN_W'(k_r)) ? k_r : left[CW-1:0];
                                last_fr <= (left <= LEN_W'(k_r));
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // stream outputs
    always_comb begin
        in_ready  = 1'b0;
        enc_data  = 1'b0;
        enc_valid = 1'b0;
        enc_last  = 1'b0;
        enc_final = 1'b0;
        par_ready = 1'b0;
        tx_data   = 1'b0;
        tx_valid  = 1'b0;
        tx_eof    = 1'b0;
        tx_final  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_INFO: begin
                in_ready  = enc_ready && tx_ready;
                enc_valid = in_valid && tx_ready;
                enc_data  = in_data;
                enc_last  = (cnt == k_r - CW'(1));
                enc_final = last_fr;
                tx_valid  = in_valid && enc_ready;
                tx_data   = in_data;
                tx_final  = last_fr;
            end
            ST_FILL: begin
                enc_valid = 1'b1;
                enc_last  = (cnt == k_r - CW'(1));
                enc_final = last_fr;
            end
            ST_PARITY: begin
                par_ready = tx_ready;
                tx_valid  = par_valid;
                tx_data   = par_data;
                tx_eof    = (cnt == p_r - CW'(1));
                tx_final  = last_fr;
            end
        endcase
    end

    AST_IN_READY_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (enc_ready && tx_ready)); // R8

    AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && par_ready)); // R8

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INFO || state == ST_FILL) |-> (cnt < k_r)); // R4

    AST_FILL_OFF_AIR: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_valid && !enc_data && !in_valid) |-> !tx_valid); // R6

    AST_EOF_NEXT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_eof && !tx_final) |=> (state == ST_INFO)); // R7

    AST_FINAL_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_eof && tx_final) |=> (state == ST_IDLE)); // R7

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state != ST_IDLE) |=> ($stable(k_r) && $stable(p_r))); // R9
endmodule

// File: tb/tb_ldpc_frame_segmenter.sv
module tb_ldpc_frame_segmenter;
    localparam int CLK_PERIOD = 10;
    localparam int UNIT  = 1;
    localparam int LEN_W = 16;
    localparam int CW    = $clog2(72 * UNIT + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [LEN_W-1:0] pay_len = '0;
    logic [1:0] n_sel = '0, rate_sel = '0;
    logic in_data = 1'b0, in_valid = 1'b0, in_ready;
    logic enc_data, enc_valid, enc_last, enc_final;
    logic enc_ready = 1'b0;
    logic par_data = 1'b0, par_valid = 1'b0, par_ready;
    logic tx_data, tx_valid, tx_eof, tx_final;
    logic tx_ready = 1'b0;
    logic rpt_valid;
    logic [LEN_W-1:0] rpt_frames;
    logic [CW-1:0] rpt_last;

    always #(CLK_PERIOD/2) clk = ~clk;

    ldpc_frame_segmenter #(.UNIT(UNIT), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pay_len(pay_len),
        .n_sel(n_sel), .rate_sel(rate_sel),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .enc_data(enc_data), .enc_valid(enc_valid), .enc_ready(enc_ready),
        .enc_last(enc_last), .enc_final(enc_final),
        .par_data(par_data), .par_valid(par_valid), .par_ready(par_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_eof(tx_eof), .tx_final(tx_final),
        .rpt_valid(rpt_valid), .rpt_frames(rpt_frames), .rpt_last(rpt_last)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model of current case
    bit running = 1'b0;
    int m_k, m_p, m_f, m_last, m_len;
    int unsigned seed;
    int in_idx, enc_f, enc_p, tx_f, tx_p, tx_total, enc_total;

    function automatic bit pay_bit(int i);
        return ^((32'(i) * 32'h2545F491) ^ seed);
    endfunction

    function automatic bit par_bit(int f, int j);
        return ^((32'(f * 131 + j) * 32'h9E3779B9) ^ seed ^ 32'h5A5A0F0F);
    endfunction

    function automatic int info_of(int f);
        return (f == m_f - 1) ? m_last : m_k;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // stream driver and beat checker
    always @(negedge clk) begin
        if (running) begin
            in_valid  = ($urandom % 4) != 0;
            in_data   = pay_bit(in_idx);
            enc_ready = ($urandom % 4) != 0;
            tx_ready  = ($urandom % 4) != 0;
            par_valid = ($urandom % 4) != 0;
            par_data  = (tx_f < m_f && tx_p >= info_of(tx_f)) ? par_bit(tx_f, tx_p - info_of(tx_f)) : 1'b0;
        end else begin
            in_valid = 0; enc_ready = 0; tx_ready = 0; par_valid = 0;
        end
        #1;
        if (in_ready) check(enc_ready && tx_ready, "R8 in_ready gating", 0, 1);
        if (par_ready) check(tx_ready && !in_ready, "R8 par_ready gating", 0, 1);
        if (in_valid && in_ready) in_idx++;
        if (enc_valid && enc_ready) begin
            automatic bit eb = (enc_p < info_of(enc_f)) ? pay_bit(enc_f * m_k + enc_p) : 1'b0;
            check(enc_f < m_f, "R4 extra encoder beat", enc_f, m_f);
            check(enc_data == eb, "R4 encoder bit", int'(enc_data), int'(eb));
            check(enc_last == (enc_p == m_k - 1), "R5 enc_last", int'(enc_last), enc_p);
            check(enc_final == (enc_f == m_f - 1), "R5 enc_final", int'(enc_final), enc_f);
            enc_total++;
            if (enc_p == m_k - 1) begin enc_p = 0; enc_f++; end else enc_p++;
        end
        if (tx_valid && tx_ready) begin
            automatic int inf = info_of(tx_f);
            automatic bit tb = (tx_p < inf) ? pay_bit(tx_f * m_k + tx_p) : par_bit(tx_f, tx_p - inf);
            check(tx_f < m_f, "R6 extra transmit beat", tx_f, m_f);
            check(tx_data == tb, "R6 transmit bit", int'(tx_data), int'(tb));
            check(tx_eof == (tx_p == inf + m_p - 1), "R7 tx_eof", int'(tx_eof), tx_p);
            check(tx_final == (tx_f == m_f - 1), "R7 tx_final", int'(tx_final), tx_f);
            tx_total++;
            if (tx_p == inf + m_p - 1) begin tx_p = 0; tx_f++; end else tx_p++;
        end
    end

    task automatic run_case(int ns, int rs, int len, bit stray);
        int mult, num, den, n, lat, exp_lat, guard;
        mult = (ns == 0) ? 1 : (ns == 1) ? 2 : 3;
        case (rs)
            0: begin num = 1; den = 2; end
            1: begin num = 2; den = 3; end
            2: begin num = 3; den = 4; end
            default: begin num = 5; den = 6; end
        endcase
        n = 24 * UNIT * mult;
        m_k = n * num / den;
        m_p = n - m_k;
        m_len = len;
        m_f = (len + m_k - 1) / m_k;
        m_last = (len == 0) ? 0 : len - (m_f - 1) * m_k;
        seed = $urandom;
        in_idx = 0; enc_f = 0; enc_p = 0; tx_f = 0; tx_p = 0; tx_total = 0; enc_total = 0;
        @(negedge clk);
        running  = 1'b1;
        start    = 1'b1;
        pay_len  = LEN_W'(len);
        n_sel    = 2'(ns);
        rate_sel = 2'(rs);
        @(posedge clk);
        #1;
        start = 1'b0;
        lat = 0;
        while (!rpt_valid && lat < 1000) begin
            @(posedge clk); #1; lat++;
        end
        exp_lat = (len == 0) ? 0 : (len - 1) / m_k + 1;
        check(lat == exp_lat, "R3 report latency", lat, exp_lat);
        check(int'(rpt_frames) == m_f, "R2 frame count", int'(rpt_frames), m_f);
        check(int'(rpt_last) == m_last, "R2 last frame size", int'(rpt_last), m_last);
        if (stray) begin
            @(negedge clk);
            start = 1'b1; pay_len = 5; n_sel = 2'(3 - ns); rate_sel = 2'(3 - rs);
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (tx_total < len + m_f * m_p && guard < 20000) begin
            @(posedge clk); guard++;
        end
        repeat (6) @(posedge clk);
        @(negedge clk);
        running = 1'b0;
        #2;
        check(tx_total == len + m_f * m_p, "R7 transmit total", tx_total, len + m_f * m_p);
        check(enc_total == m_f * m_k, "R4 encoder total", enc_total, m_f * m_k);
        check(in_idx == len, "R2 payload consumed", in_idx, len);
        if (stray) begin
            check(int'(rpt_frames) == m_f, "R9 report kept after stray start", int'(rpt_frames), m_f);
            check(int'(rpt_last) == m_last, "R9 last size kept after stray start", int'(rpt_last), m_last);
        end
        // R1 checked through k-derived totals for this select pair
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!in_ready && !enc_valid && !tx_valid && !par_ready, "reset streams idle", 1, 0);
        check(!rpt_valid, "reset report", int'(rpt_valid), 0);
        for (int ns = 0; ns < 4; ns++) begin
            for (int rs = 0; rs < 4; rs++) begin
                for (int idx = 0; idx < 10; idx++) begin
                    int mult, k, len;
                    mult = (ns == 0) ? 1 : (ns == 1) ? 2 : 3;
                    k = mult * UNIT * ((rs == 0) ? 12 : (rs == 1) ? 16 : (rs == 2) ? 18 : 20);
                    case (idx)
                        0: len = 0;
                        1: len = 1;
                        2: len = k - 1;
                        3: len = k;
                        4: len = k + 1;
                        5: len = 2 * k;
                        6: len = 2 * k + 5;
                        7: len = 3 * k - 1;
                        default: len = 1 + int'($urandom % 150);
                    endcase
                    run_case(ns, rs, len, len > k);
                end
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule